// File: doc/BRIEF.md
# Multiplexed Bidirectional I/O Port

This block is an eight-pin bidirectional port that a processor reaches through a small register window. A direction register and an output data latch decide each pin's tri-state enable and driven value. A port read returns the pin levels after a two-flop synchronizer. Software can use the latch read path for read-modify-write sequences, because that path returns what was written and not what the pins show.

Each pin can be taken over by another function. The upper half can become analog inputs: the driver turns off, the port read shows zero, and the raw pad level goes to an analog output. The lower half can carry four high external address bits from a memory bus controller. The two top pins can carry two PWM signals. Every mode-select input is active low, so a cleared configuration word gives the power-on defaults: upper half analog, lower half on the address bus.

Top module: `gpio_mux_port`

## Requirements
- R1: On reset the output latch is 0x00 and the direction register is 0xFF, so every pin is an input.
- R2: With no override active, a direction bit of 1 turns the pin driver off (pad_oe_o bit 0). A direction bit of 0 turns it on. pad_out_o carries the latch bit.
- R3: A read at address 1 returns the latch contents, whatever the pad levels are.
- R4: A write at address 0 or 1 loads the latch. A write at address 2 loads the direction register. A write at address 3 changes nothing, and a read at address 3 returns 0x00.
- R5: A read at address 0 returns each digital pin's pad level as sampled by a two-flop synchronizer. A pad change made just after a clock edge becomes visible after the second following edge. This holds for both input and output pins.
- R6: When upper_dig_i is 0, pins 7..4 are analog. Their drivers are off, they read as 0 at address 0, and ana_o carries the raw pad levels. ana_o is 0 when upper_dig_i is 1.
- R7: When lower_io_i is 0, pins 3..0 are driven with bus_addr_i, with the driver on, whatever the direction and latch hold.
- R8: When pwm_map_n_i is 0 and the upper half is digital, pin 7 drives pwm_b_i and pin 6 drives pwm_c_i, both with the driver on. Pins 5..4 are unaffected.
- R9: Analog mode outranks PWM mapping. With both active, pins 7 and 6 are not driven.
- R10: Reads are combinational. A read of the register being written in the same cycle returns the old value, and the new value appears after the edge.
- R11: The latch can still be written while PWM owns pins 7 and 6. The written value appears on those pins once the mapping is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 2 | Register select: 0 port, 1 latch, 2 direction, 3 unused |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| upper_dig_i | input | 1 | 1 = pins 7..4 digital, 0 = analog |
| lower_io_i | input | 1 | 1 = pins 3..0 digital, 0 = address bus |
| pwm_map_n_i | input | 1 | 0 = pins 7 and 6 carry PWM B and C |
| pwm_b_i | input | 1 | PWM channel B for pin 7 |
| pwm_c_i | input | 1 | PWM channel C for pin 6 |
| bus_addr_i | input | 4 | External address bits for pins 3..0 |
| pad_in_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output values |
| pad_oe_o | output | 8 | Pad driver enables, 1 = drive |
| ana_o | output | 4 | Raw upper pad levels passed to the analog converter |

## Verification
Two functions can meet in one cycle. The first is a register write that collides with a read of the same register. The bench raises the strobe and samples rdata_o before the edge, expecting the old value, then samples again after the edge. The second is a latch write while PWM owns pins 7 and 6. The bench writes new data during the mapping and checks that the pads still follow the PWM inputs while the latch read shows the new data. It then releases the mapping and expects the written bits on the pads.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  typedef enum logic [1:0] {
    REG_PORT  = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR   = 2'd2,
    REG_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, sync_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // cycles since reset, for latency check only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= 2'd0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (sync_o == $past(pad_i, 2))); // R5
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_mux_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pin_sync_i,
  input  logic [W-1:0] ana_mask_i,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] rdata_o
);
  reg_addr_e    sel;
  logic [W-1:0] latch_q, dir_q;

  assign sel = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '1;
    end else if (wr_en_i) begin
      case (sel)
        REG_PORT, REG_LATCH: latch_q <= wdata_i;
        REG_DIR:             dir_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      REG_PORT:  rdata_o = pin_sync_i & ~ana_mask_i;
      REG_LATCH: rdata_o = latch_q;
      REG_DIR:   rdata_o = dir_q;
      default:   rdata_o = '0;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i == 2'd0 || addr_i == 2'd1)) |=> (latch_o == $past(wdata_i))); // R4
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd2) |=> (dir_o == $past(wdata_i))); // R4
  AST_NONE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd3) |=> ($stable(latch_o) && $stable(dir_o))); // R4
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd2) |=> $stable(dir_o)); // R2
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl #(
  parameter int W  = 8,
  parameter int BW = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  latch_i,
  input  logic [W-1:0]  dir_i,
  input  logic          upper_dig_i,
  input  logic          lower_io_i,
  input  logic          pwm_map_n_i,
  input  logic          pwm_b_i,
  input  logic          pwm_c_i,
  input  logic [BW-1:0] bus_addr_i,
  output logic [W-1:0]  pad_out_o,
  output logic [W-1:0]  pad_oe_o,
  output logic [W-1:0]  ana_mask_o
);
  localparam int HALF = W / 2;

  for (genvar i = 0; i < W; i++) begin : g_pin
    localparam bit UPPER = (i >= HALF);
    logic alt_en, alt_val, bus_en, bus_val, ana_en;
    logic out_d, oe_d;

    if (i == W - 1) begin : g_pwm_b
      assign alt_en  = ~pwm_map_n_i;
      assign alt_val = pwm_b_i;
    end else if (i == W - 2) begin : g_pwm_c
      assign alt_en  = ~pwm_map_n_i;
      assign alt_val = pwm_c_i;
    end else begin : g_no_alt
      assign alt_en  = 1'b0;
      assign alt_val = 1'b0;
    end

    if (UPPER) begin : g_upper
      assign ana_en  = ~upper_dig_i;
      assign bus_en  = 1'b0;
      assign bus_val = 1'b0;
    end else begin : g_lower
      assign ana_en  = 1'b0;
      assign bus_en  = ~lower_io_i;
      assign bus_val = bus_addr_i[i];
    end

    // priority: analog, bus, pwm, register control
    always_comb begin
      if (ana_en) begin
        out_d = 1'b0;
        oe_d  = 1'b0;
      end else if (bus_en) begin
        out_d = bus_val;
        oe_d  = 1'b1;
      end else if (alt_en) begin
        out_d = alt_val;
        oe_d  = 1'b1;
      end else begin
        out_d = latch_i[i];
        oe_d  = ~dir_i[i];
      end
    end

    assign pad_out_o[i]  = out_d;
    assign pad_oe_o[i]   = oe_d;
    assign ana_mask_o[i] = ana_en;
  end

  AST_ANALOG_DRIVER_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upper_dig_i |-> (pad_oe_o[W-1:HALF] == '0)); // R6
  AST_BUS_OWNS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lower_io_i |-> (pad_oe_o[HALF-1:0] == '1 && pad_out_o[HALF-1:0] == bus_addr_i)); // R7
  AST_PWM_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upper_dig_i && !pwm_map_n_i) |->
      (pad_out_o[W-1] == pwm_b_i && pad_out_o[W-2] == pwm_c_i && pad_oe_o[W-1] && pad_oe_o[W-2])); // R8
  AST_ANALOG_OVER_PWM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upper_dig_i && !pwm_map_n_i) |-> (!pad_oe_o[W-1] && !pad_oe_o[W-2])); // R9
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port #(
  parameter int W  = 8,
  parameter int BW = W / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic          upper_dig_i,
  input  logic          lower_io_i,
  input  logic          pwm_map_n_i,
  input  logic          pwm_b_i,
  input  logic          pwm_c_i,
  input  logic [BW-1:0] bus_addr_i,
  input  logic [W-1:0]  pad_in_i,
  output logic [W-1:0]  pad_out_o,
  output logic [W-1:0]  pad_oe_o,
  output logic [BW-1:0] ana_o
);
  localparam int HALF = W / 2;

  logic [W-1:0] pin_sync, latch, dir, ana_mask;

  gpio_pad_sync #(.W(W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_in_i),
    .sync_o (pin_sync)
  );

  gpio_port_regs #(.W(W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pin_sync_i (pin_sync),
    .ana_mask_i (ana_mask),
    .latch_o    (latch),
    .dir_o      (dir),
    .rdata_o    (rdata_o)
  );

  gpio_pin_ctl #(.W(W), .BW(BW)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .latch_i     (latch),
    .dir_i       (dir),
    .upper_dig_i (upper_dig_i),
    .lower_io_i  (lower_io_i),
    .pwm_map_n_i (pwm_map_n_i),
    .pwm_b_i     (pwm_b_i),
    .pwm_c_i     (pwm_c_i),
    .bus_addr_i  (bus_addr_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .ana_mask_o  (ana_mask)
  );

  // raw pad level to the converter, unsynchronized
  assign ana_o = upper_dig_i ? '0 : pad_in_i[W-1:HALF];

  AST_ANALOG_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upper_dig_i && addr_i == 2'd0) |-> (rdata_o[W-1:HALF] == '0)); // R6
endmodule

// File: tb/gpio_mux_port_test.sv
`timescale 1ns/1ps
module gpio_mux_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       upper_dig = 1'b0, lower_io = 1'b0, pwm_map_n = 1'b1;
  logic       pwm_b = 1'b0, pwm_c = 1'b0;
  logic [3:0] bus_addr = 4'hA;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe;
  logic [3:0] ana;

  always #2 clk = ~clk;

  gpio_mux_port uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .upper_dig_i(upper_dig), .lower_io_i(lower_io),
    .pwm_map_n_i(pwm_map_n), .pwm_b_i(pwm_b), .pwm_c_i(pwm_c), .bus_addr_i(bus_addr),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .ana_o(ana)
  );

  typedef enum int {OBS_RDATA, OBS_OUT, OBS_OE, OBS_ANA} obs_e;
  typedef struct {
    obs_e       what;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // monitor: compares queued items 1 ns after each falling edge
  always begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.what)
        OBS_RDATA: act = rdata;
        OBS_OUT:   act = pad_out;
        OBS_OE:    act = pad_oe;
        default:   act = {4'h0, ana};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: %s actual %h expected %h", it.req, it.what.name(), act, it.exp);
      end
    end
  end

  task automatic expect_now(obs_e w, logic [7:0] e, string r);
    item_t it;
    it.what = w; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(logic [1:0] a, logic [7:0] e, string r);
    addr = a;
    expect_now(OBS_RDATA, e, r);
    step();
  endtask

  task automatic pads(logic [7:0] e_out, logic [7:0] e_oe, string r);
    expect_now(OBS_OUT, e_out, r);
    expect_now(OBS_OE, e_oe, r);
    step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset values
    reg_rd(2'd1, 8'h00, "R1");
    reg_rd(2'd2, 8'hFF, "R1");
    // defaults: upper analog (R6), lower bus (R7)
    pads(8'h0A, 8'h0F, "R7");

    pad_in = 8'hB5;
    repeat (3) step();
    reg_rd(2'd0, 8'h05, "R6");
    expect_now(OBS_ANA, 8'h0B, "R6");
    step();

    upper_dig = 1'b1; lower_io = 1'b1;
    pads(8'h00, 8'h00, "R2");
    expect_now(OBS_ANA, 8'h00, "R6");
    step();

    reg_wr(2'd1, 8'h3C);
    reg_rd(2'd1, 8'h3C, "R4");
    reg_wr(2'd2, 8'hF0);
    pads(8'h3C, 8'h0F, "R2");

    // R3 latch read is not the pad
    reg_rd(2'd1, 8'h3C, "R3");
    reg_rd(2'd0, 8'hB5, "R5");

    // R5 synchronizer latency
    pad_in = 8'h5A;
    repeat (3) step();
    reg_rd(2'd0, 8'h5A, "R5");
    pad_in = 8'hFF;
    reg_rd(2'd0, 8'h5A, "R5");
    reg_rd(2'd0, 8'h5A, "R5");
    reg_rd(2'd0, 8'hFF, "R5");

    // R4 address map
    reg_wr(2'd0, 8'h81);
    reg_rd(2'd1, 8'h81, "R4");
    reg_wr(2'd3, 8'h55);
    reg_rd(2'd1, 8'h81, "R4");
    reg_rd(2'd2, 8'hF0, "R4");
    reg_rd(2'd3, 8'h00, "R4");

    // R10 read during write
    wr_en = 1'b1; addr = 2'd1; wdata = 8'h77;
    expect_now(OBS_RDATA, 8'h81, "R10");
    step();
    wr_en = 1'b0;
    expect_now(OBS_RDATA, 8'h77, "R10");
    step();

    // R8 pwm mapping, pin 7 set as input still driven
    reg_wr(2'd2, 8'h80);
    pwm_map_n = 1'b0; pwm_b = 1'b1; pwm_c = 1'b0;
    pads(8'hB7, 8'hFF, "R8");
    pwm_b = 1'b0; pwm_c = 1'b1;
    pads(8'h77, 8'hFF, "R8");

    // R11 latch write while pwm owns pins 7 and 6
    pwm_b = 1'b1; pwm_c = 1'b1;
    reg_wr(2'd1, 8'h3F);
    pads(8'hFF, 8'hFF, "R11");
    reg_rd(2'd1, 8'h3F, "R11");
    pwm_map_n = 1'b1;
    pads(8'h3F, 8'h7F, "R11");

    // R9 analog outranks pwm
    pwm_map_n = 1'b0; upper_dig = 1'b0;
    pads(8'h0F, 8'h0F, "R9");

    // R7 bus ignores direction and latch
    reg_wr(2'd2, 8'hFF);
    lower_io = 1'b0; bus_addr = 4'h5;
    pads(8'h05, 8'h0F, "R7");

    step();
    step();
    done = 1'b1;
    finish_run();
  end
endmodule